// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the protocol engine of a byte-addressed memory that answers on a two-wire serial bus. An external front end hands it filtered samples of the clock and data lines together with one-cycle strobes for start and stop conditions. The engine drives the data line only through a pull-down enable. It decodes the control byte, keeps a 10-bit word pointer, and serves byte writes, page writes, current-address reads, random reads and sequential reads. The memory array sits outside with a one-cycle synchronous read port. Writes are passed byte by byte to a separate page-buffer block, which owns the commit and its timing and reports a busy flag while a commit is under way.

The control byte, most significant bit first, carries a 4-bit device code in bits 7..4, block-select bits in bits 3..1 and the direction in bit 0. With the default of two block bits, bits 2..1 form the upper two word-address bits and bit 3 is ignored. The engine is a state machine with states ST_IDLE, ST_CTRL (receive control byte), ST_CACK (acknowledge control), ST_ADDR (receive word address), ST_AACK, ST_WDAT (receive data), ST_DACK, ST_RDAT (transmit data) and ST_RACK (sample the master's acknowledge). A start strobe moves any state to ST_CTRL and a stop strobe moves any state to ST_IDLE. On a falling clock edge: ST_CTRL goes to ST_CACK after eight bits if the control byte is accepted, else to ST_IDLE; ST_CACK goes to ST_RDAT for a read and ST_ADDR for a write; ST_ADDR goes to ST_AACK, ST_AACK to ST_WDAT, ST_WDAT to ST_DACK and ST_DACK back to ST_WDAT; ST_RDAT goes to ST_RACK after eight bits; ST_RACK returns to ST_RDAT on an acknowledge and to ST_IDLE without one.

Top module: `eep_i2c_target`

## Requirements
- R1: A control byte is acknowledged only when bits 7..4 equal 1010; with any other code the engine stays released and acknowledges nothing until the next start.
- R2: An accepted control byte copies its bits 2..1 into pointer bits 9..8, so the block bits pick the 256-byte block for both reads and writes.
- R3: Control bit 0 equal to 1 starts a read (the engine transmits after the control acknowledge); 0 starts a write (the next byte is a word address).
- R4: In a write, the byte after the control byte loads pointer bits 7..0; every later byte is acknowledged on the ninth clock and pushed on wr_push_o with the current pointer on wr_addr_o.
- R5: After each data byte pushed, pointer bits 3..0 advance by one and wrap inside the 16-byte page while bits 9..4 stay unchanged, so more than 16 bytes overwrite the oldest ones of that page.
- R6: A stop received during the data phase of a write with at least one byte pushed gives a single-cycle wr_commit_o pulse; a stop with no data byte gives none.
- R7: While wr_busy_i is high the control byte is not acknowledged, which lets the master poll for the end of a commit.
- R8: A read returns the byte at the pointer and advances the pointer by one after each byte sent, so a current-address read returns the byte following the last one accessed.
- R9: A random read (write control byte, word address, repeated start, read control byte) returns the byte at the loaded address.
- R10: During a read a master acknowledge brings the next byte; the pointer runs over the whole 1024-byte space and wraps from 0x3FF to 0x000.
- R11: A missing master acknowledge releases the data line; the engine sends nothing more until a new start.
- R12: A start strobe at any point, even in the middle of a byte, drops the current byte and restarts control-byte reception.
- R13: sda_pull_o high means the line is pulled low; it is low after reset and in ST_IDLE, and data bits are sent most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Filtered serial clock sample |
| sda_i | input | 1 | Filtered serial data sample |
| start_i | input | 1 | One-cycle start condition strobe |
| stop_i | input | 1 | One-cycle stop condition strobe |
| sda_pull_o | output | 1 | Pull-down enable for the data line |
| mem_addr_o | output | 10 | Read address of the memory array |
| mem_data_i | input | 8 | Read data, valid one cycle after the address |
| wr_push_o | output | 1 | One-cycle push of a received data byte |
| wr_addr_o | output | 10 | Address of the pushed byte |
| wr_data_o | output | 8 | Value of the pushed byte |
| wr_commit_o | output | 1 | One-cycle request to commit the pushed bytes |
| wr_busy_i | input | 1 | Page buffer is committing |

## Verification
The bench sweeps all sixteen device codes, so an engine that compared too few code bits would acknowledge a wrong code and be caught. Each of the four blocks is written and read back; a design that ignored the block bits would read back the same block every time. A 20-byte page write starting at offset 0xC must leave the last sixteen values in the page and its neighbours intact; carrying the page counter into bit 4 would corrupt the next page. A sequential read across 0x3FF, a clocked byte after a master no-acknowledge, a poll during a commit and a start in the middle of a byte catch a pointer that stops at the top, a line that is not released, acknowledges given while busy, and a half-received byte that survives a restart.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CACK,
        ST_ADDR,
        ST_AACK,
        ST_WDAT,
        ST_DACK,
        ST_RDAT,
        ST_RACK
    } eep_state_e;

    localparam int unsigned BYTE_W    = 8;
    localparam logic [3:0]  CTRL_CODE = 4'b1010;

endpackage

// File: rtl/eep_scl_edge.sv
module eep_scl_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    output logic rise_o,
    output logic fall_o
);

    logic scl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scl_q <= 1'b1;
        else        scl_q <= scl_i;
    end

    assign rise_o = scl_i & ~scl_q;
    assign fall_o = ~scl_i & scl_q;

endmodule

// File: rtl/eep_addr_ptr.sv
module eep_addr_ptr #(
    parameter int BLK_W  = 2,
    parameter int WORD_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_blk_i,
    input  logic [BLK_W-1:0]          blk_i,
    input  logic                      load_word_i,
    input  logic [WORD_W-1:0]         word_i,
    input  logic                      inc_page_i,
    input  logic                      inc_full_i,
    output logic [BLK_W+WORD_W-1:0]   ptr_o
);

    localparam int ADDR_W = BLK_W + WORD_W;

    logic [ADDR_W-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load_blk_i) begin
            ptr_q[ADDR_W-1:WORD_W] <= blk_i;
        end else if (load_word_i) begin
            ptr_q[WORD_W-1:0] <= word_i;
        end else if (inc_page_i) begin
            ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + 1'b1;
        end else if (inc_full_i) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign ptr_o = ptr_q;

    AST_PAGE_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        inc_page_i |=> ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W])); // R5

    AST_READ_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_full_i && !load_blk_i && !load_word_i && !inc_page_i && (&ptr_q)) |=> (ptr_q == '0)); // R10

endmodule

// File: rtl/eep_tx_shift.sv
module eep_tx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [W-1:0] data_i,
    output logic         next_o
);

    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sr_q <= '0;
        else if (load_i)  sr_q <= data_i;
        else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};
    end

    assign next_o = sr_q[W-2];

endmodule

// File: rtl/eep_i2c_target.sv
module eep_i2c_target
    import eep_pkg::*;
#(
    parameter int BLK_W  = 2,
    parameter int WORD_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    input  logic                    start_i,
    input  logic                    stop_i,
    output logic                    sda_pull_o,
    output logic [BLK_W+WORD_W-1:0] mem_addr_o,
    input  logic [BYTE_W-1:0]       mem_data_i,
    output logic                    wr_push_o,
    output logic [BLK_W+WORD_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0]       wr_data_o,
    output logic                    wr_commit_o,
    input  logic                    wr_busy_i
);

    localparam int ADDR_W = BLK_W + WORD_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    eep_state_e state_q, state_d;

    logic              scl_rise, scl_fall, go;
    logic [BYTE_W-1:0] rx_q;
    logic [CNT_W-1:0]  bitcnt_q;
    logic              rw_q, mack_q, data_seen_q;
    logic              sda_pull_q, push_q, commit_q;
    logic [ADDR_W-1:0] wr_addr_q, ptr;
    logic [BYTE_W-1:0] wr_data_q;
    logic              byte_done, tx_last, ctrl_ok, rx_state;
    logic              load_blk, load_word, inc_page, inc_full;
    logic              tx_load, tx_shift, tx_next;

    eep_scl_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_i),
        .rise_o (scl_rise),
        .fall_o (scl_fall)
    );

    assign go        = scl_fall && !start_i && !stop_i;
    assign byte_done = (bitcnt_q == CNT_FULL);
    assign tx_last   = (bitcnt_q == CNT_LAST);
    assign ctrl_ok   = (rx_q[BYTE_W-1:BYTE_W-4] == CTRL_CODE) && !wr_busy_i;
    assign rx_state  = (state_q == ST_CTRL) || (state_q == ST_ADDR) || (state_q == ST_WDAT);

    assign load_blk  = go && (state_q == ST_CTRL) && byte_done && ctrl_ok;
    assign load_word = go && (state_q == ST_ADDR) && byte_done;
    assign inc_page  = go && (state_q == ST_WDAT) && byte_done;
    assign inc_full  = go && (state_q == ST_RDAT) && tx_last;
    assign tx_load   = go && (((state_q == ST_CACK) && rw_q) || ((state_q == ST_RACK) && mack_q));
    assign tx_shift  = go && (state_q == ST_RDAT) && !tx_last;

    eep_addr_ptr #(
        .BLK_W  (BLK_W),
        .WORD_W (WORD_W),
        .PAGE_W (PAGE_W)
    ) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_blk_i  (load_blk),
        .blk_i       (rx_q[BLK_W:1]),
        .load_word_i (load_word),
        .word_i      (rx_q[WORD_W-1:0]),
        .inc_page_i  (inc_page),
        .inc_full_i  (inc_full),
        .ptr_o       (ptr)
    );

    eep_tx_shift #(.W(BYTE_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tx_load),
        .shift_i (tx_shift),
        .data_i  (mem_data_i),
        .next_o  (tx_next)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_CTRL;
        end else if (stop_i) begin
            state_d = ST_IDLE;
        end else if (scl_fall) begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_CTRL: if (byte_done) state_d = ctrl_ok ? ST_CACK : ST_IDLE;
                ST_CACK: state_d = rw_q ? ST_RDAT : ST_ADDR;
                ST_ADDR: if (byte_done) state_d = ST_AACK;
                ST_AACK: state_d = ST_WDAT;
                ST_WDAT: if (byte_done) state_d = ST_DACK;
                ST_DACK: state_d = ST_WDAT;
                ST_RDAT: if (tx_last) state_d = ST_RACK;
                ST_RACK: state_d = mack_q ? ST_RDAT : ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q        <= '0;
            bitcnt_q    <= '0;
            rw_q        <= 1'b0;
            mack_q      <= 1'b0;
            data_seen_q <= 1'b0;
            sda_pull_q  <= 1'b0;
            push_q      <= 1'b0;
            commit_q    <= 1'b0;
            wr_addr_q   <= '0;
            wr_data_q   <= '0;
        end else begin
            push_q   <= 1'b0;
            commit_q <= 1'b0;
            if (start_i) begin
                bitcnt_q    <= '0;
                sda_pull_q  <= 1'b0;
                data_seen_q <= 1'b0;
            end else if (stop_i) begin
                sda_pull_q  <= 1'b0;
                commit_q    <= data_seen_q &&
                               ((state_q == ST_WDAT) || (state_q == ST_DACK));
                data_seen_q <= 1'b0;
            end else begin
                if (scl_rise && rx_state && !byte_done) begin
                    rx_q     <= {rx_q[BYTE_W-2:0], sda_i};
                    bitcnt_q <= bitcnt_q + 1'b1;
                end
                if (scl_rise && (state_q == ST_RACK)) begin
                    mack_q <= ~sda_i;
                end
                if (scl_fall) begin
                    case (state_q)
                        ST_CTRL: begin
                            if (byte_done && ctrl_ok) begin
                                sda_pull_q <= 1'b1;
                                rw_q       <= rx_q[0];
                            end
                        end
                        ST_CACK: begin
                            sda_pull_q <= rw_q ? ~mem_data_i[BYTE_W-1] : 1'b0;
                            bitcnt_q   <= '0;
                        end
                        ST_ADDR: begin
                            if (byte_done) sda_pull_q <= 1'b1;
                        end
                        ST_WDAT: begin
                            if (byte_done) begin
                                sda_pull_q  <= 1'b1;
                                push_q      <= 1'b1;
                                wr_addr_q   <= ptr;
                                wr_data_q   <= rx_q;
                                data_seen_q <= 1'b1;
                            end
                        end
                        ST_AACK, ST_DACK: begin
                            sda_pull_q <= 1'b0;
                            bitcnt_q   <= '0;
                        end
                        ST_RDAT: begin
                            if (tx_last) begin
                                sda_pull_q <= 1'b0;
                            end else begin
                                sda_pull_q <= ~tx_next;
                                bitcnt_q   <= bitcnt_q + 1'b1;
                            end
                        end
                        ST_RACK: begin
                            sda_pull_q <= mack_q ? ~mem_data_i[BYTE_W-1] : 1'b0;
                            bitcnt_q   <= '0;
                        end
                        default: sda_pull_q <= 1'b0;
                    endcase
                end
            end
        end
    end

    assign sda_pull_o  = sda_pull_q;
    assign mem_addr_o  = ptr;
    assign wr_push_o   = push_q;
    assign wr_addr_o   = wr_addr_q;
    assign wr_data_o   = wr_data_q;
    assign wr_commit_o = commit_q;

    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == ST_CTRL) && !sda_pull_o); // R12

    AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_pull_o) && (state_q == ST_CACK)) |-> !$past(wr_busy_i)); // R7

    AST_PUSH_ON_DATA_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_push_o |-> (state_q == ST_DACK) && sda_pull_o); // R4

    AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |-> (state_q == ST_IDLE) && $past(stop_i)); // R6

    AST_RELEASE_ON_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RACK) && go && !mack_q) |=> (state_q == ST_IDLE) && !sda_pull_o); // R11

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_pull_o); // R13

endmodule

// File: tb/eep_i2c_target_tb_top.sv
module eep_i2c_target_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int H          = 4;
    localparam int BUSY_CYC   = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       start_s = 1'b0, stop_s = 1'b0;
    logic       sda_pull, wr_push, wr_commit, busy;
    logic [9:0] mem_addr, wr_addr;
    logic [7:0] mem_rdata, wr_data;
    logic       sda_bus;

    int checks = 0, fails = 0;
    int push_cnt = 0, commit_cnt = 0;

    logic [7:0] mem [1024];
    logic [7:0] exp_mem [1024];
    logic [9:0] pa [64];
    logic [7:0] pd [64];
    int         pend_n = 0, bcnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    eep_i2c_target dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .start_i     (start_s),
        .stop_i      (stop_s),
        .sda_pull_o  (sda_pull),
        .mem_addr_o  (mem_addr),
        .mem_data_i  (mem_rdata),
        .wr_push_o   (wr_push),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .wr_commit_o (wr_commit),
        .wr_busy_i   (busy)
    );

    // memory array and page buffer model
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 1024; a++) mem[a] <= 8'((a * 7 + 3) & 255);
            busy <= 1'b0;
            pend_n <= 0;
            mem_rdata <= 8'h00;
        end else begin
            mem_rdata <= mem[mem_addr];
            if (wr_push) begin
                pa[pend_n] <= wr_addr;
                pd[pend_n] <= wr_data;
                pend_n <= pend_n + 1;
                push_cnt <= push_cnt + 1;
            end
            if (wr_commit) begin
                busy <= 1'b1;
                bcnt <= BUSY_CYC;
                commit_cnt <= commit_cnt + 1;
            end else if (busy) begin
                if (bcnt == 0) begin
                    for (int i = 0; i < pend_n; i++) mem[pa[i]] <= pd[i];
                    pend_n <= 0;
                    busy <= 1'b0;
                end else begin
                    bcnt <= bcnt - 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        scl_m = 1'b0; tick(H);
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; start_s = 1'b1; tick(1);
        start_s = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; stop_s = 1'b1; tick(1);
        stop_s = 1'b0; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            scl_m = 1'b0; tick(H);
            sda_m = b[i]; tick(H);
            scl_m = 1'b1; tick(H);
        end
        scl_m = 1'b0; tick(H);
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        acked = (sda_bus == 1'b0);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            scl_m = 1'b0; tick(H);
            sda_m = 1'b1; tick(H);
            scl_m = 1'b1; tick(H);
            b[i] = sda_bus;
        end
        scl_m = 1'b0; tick(H);
        sda_m = mack ? 1'b0 : 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0; tick(H);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] ctl(input int blk, input bit rd);
        logic [1:0] b2 = blk[1:0];
        return {4'b1010, 1'b0, b2, rd};
    endfunction

    task automatic wait_ready();
        bit ack = 1'b0;
        for (int t = 0; t < 30 && !ack; t++) begin
            bus_start();
            send_byte(ctl(0, 1'b0), ack);
            bus_stop();
        end
        check(ack, "R7 ready after commit", ack, 1);
    endtask

    task automatic write_bytes(input int addr, input int n, input int base);
        bit ack;
        int c0 = commit_cnt;
        bus_start();
        send_byte(ctl(addr >> 8, 1'b0), ack);
        check(ack, "R3 write control ack", ack, 1);
        send_byte(8'(addr & 255), ack);
        check(ack, "R4 word address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            logic [7:0] v = 8'((base + i) & 255);
            send_byte(v, ack);
            check(ack, "R4 data ack", ack, 1);
            exp_mem[(addr & 10'h3F0) | ((addr + i) & 15)] = v;
        end
        bus_stop();
        check(commit_cnt == c0 + 1, "R6 commit pulse", commit_cnt - c0, 1);
    endtask

    task automatic read_seq(input int addr, input int n, input bit random, input string req);
        bit ack;
        logic [7:0] b;
        bus_start();
        if (random) begin
            send_byte(ctl(addr >> 8, 1'b0), ack);
            send_byte(8'(addr & 255), ack);
            bus_start();
        end
        send_byte(ctl(addr >> 8, 1'b1), ack);
        check(ack, "R3 read control ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            int a = (addr + k) & 1023;
            recv_byte(k < n - 1, b);
            check(b == exp_mem[a], req, b, exp_mem[a]);
        end
    endtask

    initial begin
        bit ack;
        logic [7:0] b;
        int c0, p0;

        for (int a = 0; a < 1024; a++) exp_mem[a] = 8'((a * 7 + 3) & 255);
        tick(5);
        check(sda_pull == 1'b0 && wr_push == 1'b0 && wr_commit == 1'b0,
              "R13 reset released", sda_pull, 0);
        rst_n = 1'b1;
        tick(5);

        // R1: sweep every device code
        for (int code = 0; code < 16; code++) begin
            c0 = commit_cnt;
            bus_start();
            send_byte({4'(code), 4'b0000}, ack);
            check(ack == (code == 10), "R1 device code", ack, code == 10);
            if (code != 10) begin
                send_byte(8'h00, ack);
                check(!ack, "R1 ignored after bad code", ack, 0);
            end
            bus_stop();
            check(commit_cnt == c0, "R6 no commit without data", commit_cnt - c0, 0);
        end

        // R2 R7: one byte per block, poll while busy
        for (int blk = 0; blk < 4; blk++) begin
            write_bytes(blk * 256 + 8'h40 + blk, 1, 8'hA0 + blk);
            bus_start();
            send_byte(ctl(0, 1'b0), ack);
            check(!ack, "R7 nack while busy", ack, 0);
            bus_stop();
            wait_ready();
        end
        for (int blk = 0; blk < 4; blk++) begin
            read_seq(blk * 256 + 8'h40 + blk, 1, 1'b1, "R2 R9 block readback");
            bus_stop();
        end

        // R8: current-address read after a read of 0x343
        bus_start();
        send_byte(ctl(3, 1'b1), ack);
        recv_byte(1'b0, b);
        check(b == exp_mem[10'h344], "R8 current address", b, exp_mem[10'h344]);
        bus_stop();

        // R5: 20-byte page write from offset 0xC of block 2
        p0 = push_cnt;
        write_bytes(10'h21C, 20, 8'h30);
        check(push_cnt == p0 + 20, "R4 push count", push_cnt - p0, 20);
        wait_ready();
        read_seq(10'h20F, 19, 1'b1, "R5 page wrap contents");
        bus_stop();

        // R10 R11: sequential read across the top of the space
        read_seq(10'h3FE, 4, 1'b1, "R10 wrap read");
        recv_byte(1'b0, b);
        check(b == 8'hFF, "R11 released after nack", b, 8'hFF);
        bus_stop();
        bus_start();
        send_byte(ctl(0, 1'b1), ack);
        recv_byte(1'b0, b);
        check(b == exp_mem[2], "R8 pointer after wrap", b, exp_mem[2]);
        bus_stop();
        bus_start();
        send_byte(ctl(0, 1'b1), ack);
        recv_byte(1'b0, b);
        check(b == exp_mem[3], "R8 next current read", b, exp_mem[3]);
        bus_stop();

        // R12: start in the middle of a byte
        bus_start();
        for (int i = 0; i < 4; i++) begin
            scl_m = 1'b0; tick(H);
            sda_m = 1'b1; tick(H);
            scl_m = 1'b1; tick(H);
        end
        read_seq(10'h1A5, 2, 1'b1, "R12 restart mid-byte");
        bus_stop();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule